// File: doc/BRIEF.md
# Dual-Channel Display Pixel Port Formatter

This block takes a stream of 24-bit pixels and steers it onto two 12-bit double-data-rate display output ports, port B and port C. Each port is modelled as a pair of words per clock: a rise word, sent on the rising edge of the port clock, and a fall word, sent on the falling edge. Serializers and clock generation sit outside the block. The input side offers two pixels per beat on a valid/ready handshake. The even lane holds the even-numbered pixel and the odd lane holds the odd-numbered one. A line-start marker on a beat makes its even-lane pixel pixel 0 of a new line.

There are three formats. In single-port format each beat sends one pixel on one port, low half on the rise word and high half on the fall word. In high-low format the two ports are ganged into one 24-bit bus: the low halves of both pixels go on one port and the high halves on the other, so one whole pixel leaves per edge. In odd-even format each port carries complete pixels, even ones on one port and odd ones on the other. A swap bit exchanges the roles of the ports. Format and swap are latched only on a line-start beat, so a line never mixes formats. In a dual format, horizontal values must be a multiple of two pixel clocks, and a sticky flag reports a line start that breaks this rule.

Control is a three-state machine. ST_HUNT waits for the first line start and throws away any beat that arrives before it. ST_LINE streams accepted beats. ST_STARVED holds the outputs blank while no input is offered. The transitions are: ST_HUNT to ST_LINE on an accepted line-start beat; ST_LINE to ST_STARVED when valid drops; ST_STARVED to ST_LINE when valid returns.

Top module: `pxfmt_dual_ddr`

## Requirements
- R1: While reset is held, in_ready, out_active, timing_err and all port words are 0. From the first clock after reset is released, in_ready is 1.
- R2: Single-port format (cfg_fmt 0), swap 0: an accepted beat gives pc_rise = even[11:0] and pc_fall = even[23:12] one clock later. Port B is 0 and the odd lane is ignored. With swap 1 the pixel goes to port B and port C is 0.
- R3: High-low format (cfg_fmt 1), swap 0: pc_rise = even[11:0], pc_fall = odd[11:0], pb_rise = even[23:12], pb_fall = odd[23:12]. Swap 1 exchanges ports B and C.
- R4: Odd-even format (cfg_fmt 2), swap 0: pc_rise = even[11:0], pc_fall = even[23:12], pb_rise = odd[11:0], pb_fall = odd[23:12]. Swap 1 exchanges ports B and C.
- R5: An accepted beat appears on the ports exactly one clock after acceptance, with out_active 1. A clock with in_valid low is followed by out_active 0 and all port words 0.
- R6: Format and swap are sampled only on an accepted beat with in_sol high. Changes at any other time have no effect on the current line.
- R7: After reset, beats accepted before the first line start produce blank output (out_active 0, words 0).
- R8: timing_err goes high one clock after an accepted line-start beat that selects a dual format (1 or 2) while cfg_hactive or cfg_htotal is odd. It then stays high until reset. Odd values in single format do not set it.
- R9: cfg_fmt value 3 behaves as single-port format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 2 | Format select: 0 single, 1 high-low, 2 odd-even, 3 single |
| cfg_swap | input | 1 | Exchange the roles of ports B and C |
| cfg_hactive | input | 12 | Programmed active width in pixels |
| cfg_htotal | input | 12 | Programmed horizontal period in pixel clocks |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block accepts beats |
| in_sol | input | 1 | Beat starts a new line |
| in_pix_even | input | 24 | Even-numbered pixel of the beat |
| in_pix_odd | input | 24 | Odd-numbered pixel of the beat |
| pb_rise | output | 12 | Port B rising-edge word |
| pb_fall | output | 12 | Port B falling-edge word |
| pc_rise | output | 12 | Port C rising-edge word |
| pc_fall | output | 12 | Port C falling-edge word |
| out_active | output | 1 | Port words carry pixel data this clock |
| timing_err | output | 1 | Sticky horizontal granularity error |

## Verification
The assertions assume that reset is held low for at least one clock before any beat is offered. They also assume that in_valid, in_sol and the configuration inputs change only away from the rising edge, so that each one is seen as a settled level. The bench drives every input on the falling edge and releases reset only after several clocks. It changes configuration in the middle of lines without a line start to probe the latching rule, and it inserts gaps with valid low to exercise the starved state.

// File: rtl/pxfmt_pkg.sv
package pxfmt_pkg;

    typedef enum logic [1:0] {
        FMT_SINGLE  = 2'd0,
        FMT_HILO    = 2'd1,
        FMT_ODDEVEN = 2'd2,
        FMT_RSVD    = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_LINE    = 2'd1,
        ST_STARVED = 2'd2
    } lane_st_e;

endpackage

// File: rtl/pxfmt_steer.sv
module pxfmt_steer
    import pxfmt_pkg::*;
#(
    parameter int HALF_W = 12
) (
    input  fmt_e                  fmt,
    input  logic                  swap,
    input  logic [2*HALF_W-1:0]   pix_even,
    input  logic [2*HALF_W-1:0]   pix_odd,
    output logic [HALF_W-1:0]     b_rise,
    output logic [HALF_W-1:0]     b_fall,
    output logic [HALF_W-1:0]     c_rise,
    output logic [HALF_W-1:0]     c_fall
);
    localparam int PIX_W = 2 * HALF_W;

    logic [HALF_W-1:0] even_lo, even_hi, odd_lo, odd_hi;
    logic [HALF_W-1:0] pri_rise, pri_fall, sec_rise, sec_fall;

    assign even_lo = pix_even[HALF_W-1:0];
    assign even_hi = pix_even[PIX_W-1:HALF_W];
    assign odd_lo  = pix_odd[HALF_W-1:0];
    assign odd_hi  = pix_odd[PIX_W-1:HALF_W];

    // primary port is C unless swapped
    always_comb begin
        unique case (fmt)
            FMT_HILO: begin
                pri_rise = even_lo;
                pri_fall = odd_lo;
                sec_rise = even_hi;
                sec_fall = odd_hi;
            end
            FMT_ODDEVEN: begin
                pri_rise = even_lo;
                pri_fall = even_hi;
                sec_rise = odd_lo;
                sec_fall = odd_hi;
            end
            default: begin
                pri_rise = even_lo;
                pri_fall = even_hi;
                sec_rise = '0;
                sec_fall = '0;
            end
        endcase
    end

    assign c_rise = swap ? sec_rise : pri_rise;
    assign c_fall = swap ? sec_fall : pri_fall;
    assign b_rise = swap ? pri_rise : sec_rise;
    assign b_fall = swap ? pri_fall : sec_fall;

endmodule

// File: rtl/pxfmt_hcheck.sv
module pxfmt_hcheck
    import pxfmt_pkg::*;
#(
    parameter int HCNT_W    = 12,
    parameter int DUAL_GRAN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_en,
    input  fmt_e              fmt,
    input  logic [HCNT_W-1:0] hactive,
    input  logic [HCNT_W-1:0] htotal,
    output logic              err
);
    logic dual_fmt;
    logic misfit;

    assign dual_fmt = (fmt == FMT_HILO) || (fmt == FMT_ODDEVEN);
    assign misfit   = ((32'(hactive) % DUAL_GRAN) != 0) ||
                      ((32'(htotal)  % DUAL_GRAN) != 0);

    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (chk_en && dual_fmt && misfit)
            err <= 1'b1;
    end

    // R8: once raised, the flag is held until reset
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

endmodule

// File: rtl/pxfmt_dual_ddr.sv
module pxfmt_dual_ddr
    import pxfmt_pkg::*;
#(
    parameter int HALF_W = 12,
    parameter int HCNT_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_fmt,
    input  logic                 cfg_swap,
    input  logic [HCNT_W-1:0]    cfg_hactive,
    input  logic [HCNT_W-1:0]    cfg_htotal,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_sol,
    input  logic [2*HALF_W-1:0]  in_pix_even,
    input  logic [2*HALF_W-1:0]  in_pix_odd,
    output logic [HALF_W-1:0]    pb_rise,
    output logic [HALF_W-1:0]    pb_fall,
    output logic [HALF_W-1:0]    pc_rise,
    output logic [HALF_W-1:0]    pc_fall,
    output logic                 out_active,
    output logic                 timing_err
);
    lane_st_e st_q, st_d;
    fmt_e     fmt_q, beat_fmt, cfg_fmt_e;
    logic     swap_q, beat_swap;
    logic     ready_q, take, line_start, emit;
    logic [HALF_W-1:0] s_b_rise, s_b_fall, s_c_rise, s_c_fall;

    assign cfg_fmt_e  = fmt_e'(cfg_fmt);
    assign in_ready   = ready_q;
    assign take       = in_valid && ready_q;
    assign line_start = take && in_sol;
    assign emit       = take && ((st_q != ST_HUNT) || in_sol);
    assign beat_fmt   = line_start ? cfg_fmt_e : fmt_q;
    assign beat_swap  = line_start ? cfg_swap  : swap_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b0;
        else
            ready_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= FMT_SINGLE;
            swap_q <= 1'b0;
        end else if (line_start) begin
            fmt_q  <= cfg_fmt_e;
            swap_q <= cfg_swap;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_HUNT;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HUNT:    if (line_start) st_d = ST_LINE;
            ST_LINE:    if (!in_valid)  st_d = ST_STARVED;
            ST_STARVED: if (in_valid)   st_d = ST_LINE;
            default:    st_d = ST_HUNT;
        endcase
    end

    pxfmt_steer #(.HALF_W(HALF_W)) i_steer (
        .fmt      (beat_fmt),
        .swap     (beat_swap),
        .pix_even (in_pix_even),
        .pix_odd  (in_pix_odd),
        .b_rise   (s_b_rise),
        .b_fall   (s_b_fall),
        .c_rise   (s_c_rise),
        .c_fall   (s_c_fall)
    );

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n || !emit) begin
            pb_rise    <= '0;
            pb_fall    <= '0;
            pc_rise    <= '0;
            pc_fall    <= '0;
            out_active <= 1'b0;
        end else begin
            pb_rise    <= s_b_rise;
            pb_fall    <= s_b_fall;
            pc_rise    <= s_c_rise;
            pc_fall    <= s_c_fall;
            out_active <= 1'b1;
        end
    end

    pxfmt_hcheck #(.HCNT_W(HCNT_W), .DUAL_GRAN(2)) i_hcheck (
        .clk     (clk),
        .rst_n   (rst_n),
        .chk_en  (line_start),
        .fmt     (cfg_fmt_e),
        .hactive (cfg_hactive),
        .htotal  (cfg_htotal),
        .err     (timing_err)
    );

    // R5: a clock without input is followed by blank output
    a_r5_starve_blank: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_active);

    // R6: latched format holds across beats without a line start
    a_r6_fmt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !in_sol) |=> ($stable(fmt_q) && $stable(swap_q)));

    // R7: nothing leaves the block before the first line start
    a_r7_hunt_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HUNT && !in_sol) |=> !out_active);

    // R2: single format with no swap leaves port B idle
    a_r2_single_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (take && beat_fmt != FMT_HILO && beat_fmt != FMT_ODDEVEN && !beat_swap)
        |=> (pb_rise == '0 && pb_fall == '0));

endmodule

// File: tb/test_pxfmt_dual_ddr.sv
`timescale 1ns/1ps
module test_pxfmt_dual_ddr;

    localparam time TCLK = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        cfg_swap = 1'b0;
    logic [11:0] cfg_hactive = 12'd640;
    logic [11:0] cfg_htotal = 12'd800;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sol = 1'b0;
    logic [23:0] in_pix_even = '0;
    logic [23:0] in_pix_odd = '0;
    logic [11:0] pb_rise, pb_fall, pc_rise, pc_fall;
    logic        out_active, timing_err;

    int compared = 0;
    int mismatched = 0;

    // model state
    int   m_fmt = 0;
    bit   m_swap = 0;
    bit   m_locked = 0;
    bit   m_err = 0;
    logic [48:0] exp_q[$];
    bit          err_q[$];
    string       tag_q[$];

    always #(TCLK/2) clk = ~clk;

    pxfmt_dual_ddr i_pxfmt_dual_ddr (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_swap(cfg_swap),
        .cfg_hactive(cfg_hactive), .cfg_htotal(cfg_htotal),
        .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol),
        .in_pix_even(in_pix_even), .in_pix_odd(in_pix_odd),
        .pb_rise(pb_rise), .pb_fall(pb_fall), .pc_rise(pc_rise), .pc_fall(pc_fall),
        .out_active(out_active), .timing_err(timing_err)
    );

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // expected {active, pb_rise, pb_fall, pc_rise, pc_fall}
    function automatic logic [48:0] model_beat(int f, bit sw, logic [23:0] ev, logic [23:0] od);
        logic [11:0] words[4];  // index 0/1: low-port rise/fall, 2/3: other port
        if (f == 1) begin
            words[0] = ev[11:0];  words[1] = od[11:0];
            words[2] = ev[23:12]; words[3] = od[23:12];
        end else if (f == 2) begin
            words[0] = ev[11:0];  words[1] = ev[23:12];
            words[2] = od[11:0];  words[3] = od[23:12];
        end else begin
            words[0] = ev[11:0];  words[1] = ev[23:12];
            words[2] = 12'h0;     words[3] = 12'h0;
        end
        if (sw) return {1'b1, words[0], words[1], words[2], words[3]};
        return {1'b1, words[2], words[3], words[0], words[1]};
    endfunction

    task automatic compare_now;
        logic [48:0] e;
        bit ee;
        string t;
        e = exp_q.pop_front();
        ee = err_q.pop_front();
        t = tag_q.pop_front();
        check({t, " ports"}, {15'd0, out_active, pb_rise, pb_fall, pc_rise, pc_fall}, {15'd0, e});
        check("R8 timing_err", {63'd0, timing_err}, {63'd0, ee});
        check("R1 ready after reset", {63'd0, in_ready}, 64'd1);
    endtask

    task automatic step(input bit v, input bit s, input int f, input bit sw,
                        input int ha, input int ht, input string tag);
        logic [23:0] ev, od;
        logic [48:0] e;
        @(negedge clk);
        compare_now();
        ev = 24'($urandom);
        od = 24'($urandom);
        in_valid = v; in_sol = s; cfg_fmt = 2'(f); cfg_swap = sw;
        cfg_hactive = 12'(ha); cfg_htotal = 12'(ht);
        in_pix_even = ev; in_pix_odd = od;
        e = '0;
        if (v) begin
            if (s) begin
                m_fmt = (f == 3) ? 0 : f;
                m_swap = sw;
                m_locked = 1;
                if (m_fmt != 0 && ((ha % 2) != 0 || (ht % 2) != 0)) m_err = 1;
            end
            if (m_locked) e = model_beat(m_fmt, m_swap, ev, od);
        end
        exp_q.push_back(e);
        err_q.push_back(m_err);
        tag_q.push_back(tag);
    endtask

    initial begin
        #(TCLK * 200000);
        mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready in reset", {63'd0, in_ready}, 64'd0);
        check("R1 ports in reset", {15'd0, out_active, pb_rise, pb_fall, pc_rise, pc_fall}, 64'd0);
        check("R1 err in reset", {63'd0, timing_err}, 64'd0);
        rst_n = 1'b1;
        exp_q.push_back('0); err_q.push_back(0); tag_q.push_back("R1");

        // R7: beats before first line start are dropped
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 640, 800, "R7");
        // R2 single, no swap; then mid-line config change (R6)
        step(1, 1, 0, 0, 640, 800, "R2");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 640, 800, "R2");
        for (int i = 0; i < 3; i++) step(1, 0, 2, 1, 640, 800, "R6");
        // R5 starvation
        for (int i = 0; i < 2; i++) step(0, 0, 0, 0, 640, 800, "R5");
        step(1, 0, 1, 0, 640, 800, "R5");
        // R2 single, swapped
        step(1, 1, 0, 1, 640, 800, "R2");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 640, 800, "R2");
        // R3 high-low both swaps
        step(1, 1, 1, 0, 640, 800, "R3");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 0, 640, 800, "R3");
        step(0, 0, 1, 0, 640, 800, "R5");
        step(1, 1, 1, 1, 640, 800, "R3");
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 640, 800, "R3");
        // R4 odd-even both swaps
        step(1, 1, 2, 0, 640, 800, "R4");
        for (int i = 0; i < 3; i++) step(1, 0, 2, 0, 640, 800, "R4");
        step(1, 1, 2, 1, 640, 800, "R4");
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 640, 800, "R4");
        // R8: odd values in single format raise nothing
        step(1, 1, 0, 0, 641, 801, "R8");
        step(1, 0, 0, 0, 641, 801, "R8");
        // R9: reserved code acts as single
        step(1, 1, 3, 0, 640, 800, "R9");
        step(1, 0, 3, 0, 640, 800, "R9");
        // R8: dual format with odd period sets the sticky flag
        step(1, 1, 1, 0, 640, 801, "R8");
        step(1, 0, 1, 0, 640, 801, "R8");
        step(1, 1, 0, 0, 640, 800, "R8");
        step(0, 0, 0, 0, 640, 800, "R8");
        // mixed traffic
        for (int i = 0; i < 300; i++) begin
            step(($urandom % 4) != 0, ($urandom % 8) == 0, int'($urandom % 4),
                 bit'($urandom % 2), 640, 800, "R6");
        end
        step(0, 0, 0, 0, 640, 800, "R5");
        @(negedge clk);
        compare_now();
        report();
        $finish;
    end

endmodule